// File: doc/BRIEF.md
# Strided Vector Load/Store Sequencer

This block turns one 256-bit SIMD strided load or store into a series of per-element memory requests. A command supplies a base byte address, an element width (four 64-bit lanes or eight 32-bit lanes) and a stride counted in elements. Register lane i maps to the memory element at distance i × stride elements from the base. The block issues one lane request per cycle over a valid/ready handshake, and each request carries its lane number as a tag.

For a load, responses may come back in any order. Each returned element is written into its register lane in a 256-bit register image, and lanes still waiting for data keep their old contents. For a store, each request carries its register lane's data to the strided address, and the memory returns one tagged acknowledgement per lane. A single-cycle completion pulse follows the last response. Only stride values from 2 to 7 are accepted. Any other value raises a one-cycle error flag and produces no memory traffic.

Top module: `strided_vec_lsu`

## Requirements
- R1: While reset is held and after it is released, `done_o`, `err_o` and `req_valid_o` are 0, `cmd_ready_o` is 1 and `vreg_o` is all zeros.
- R2: Request k of a command has tag k. Its byte address is base + k × stride × E, where E = 8 when `cmd_wide_i`=1 and E = 4 when it is 0. Tags are issued in the order 0, 1, 2 and so on, one per accepted handshake.
- R3: A command with `cmd_wide_i`=1 issues exactly 4 requests with `req_wide_o`=1. A command with `cmd_wide_i`=0 issues exactly 8 requests with `req_wide_o`=0. After that, `req_valid_o` stays low.
- R4: A command with `cmd_stride_i` equal to 0 or 1 is refused. `err_o` is 1 in the cycle after acceptance and 0 after that. No request is issued, `cmd_ready_o` stays 1 and `vreg_o` does not change.
- R5: While `req_valid_o`=1 and `req_ready_i`=0, the request's address, tag and data stay stable into the next cycle.
- R6: A load response with tag t writes lane t of `vreg_o`, whatever order the responses arrive in. In 64-bit mode it writes `rsp_data_i[63:0]` to bits [64t+63:64t]. In 32-bit mode it writes `rsp_data_i[31:0]` to bits [32t+31:32t].
- R7: Lanes of `vreg_o` whose response has not yet arrived keep their previous value. A cycle with no load response leaves `vreg_o` unchanged.
- R8: `done_o` is a one-cycle pulse in the cycle after the last outstanding response has been accepted. It is 0 before that point.
- R9: A store issues `req_we_o`=1. `req_wdata_o` carries register lane k, zero-extended to 64 bits in 32-bit mode. Store acknowledgements do not change `vreg_o`.
- R10: While a command is in progress, `cmd_ready_o` is 0, and a `cmd_valid_i` pulse has no effect on requests or on the register image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Block idle, command accepted |
| cmd_store_i | input | 1 | 1 = store, 0 = load |
| cmd_wide_i | input | 1 | 1 = 64-bit elements, 0 = 32-bit elements |
| cmd_stride_i | input | 3 | Stride in elements, legal 2..7 |
| cmd_base_i | input | 32 | Base byte address |
| cmd_wdata_i | input | 256 | Register image for stores |
| req_valid_o | output | 1 | Lane request valid |
| req_ready_i | input | 1 | Memory accepts request |
| req_addr_o | output | 32 | Lane byte address |
| req_tag_o | output | 3 | Lane number |
| req_we_o | output | 1 | Write request |
| req_wide_o | output | 1 | Access size 8 bytes (1) or 4 bytes (0) |
| req_wdata_o | output | 64 | Store data for the lane |
| rsp_valid_i | input | 1 | Response or acknowledgement present |
| rsp_tag_i | input | 3 | Lane number of the response |
| rsp_data_i | input | 64 | Load data |
| vreg_o | output | 256 | Assembled register image |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Illegal stride pulse |

## Verification
A wrong lane counter appears at the ports on the first handshake as a bad tag or address, or as an extra or missing request once the last lane has been issued. A corrupted return mask appears as `done_o` firing one cycle after a non-final response, or not firing after the final one. A bad lane decode in the register image appears in `vreg_o` one cycle after the offending response. That is why the image is compared against a model after every response, and not only at completion. The stride-legality check is observed on `err_o` and on `req_valid_o` in the cycle right after the command is accepted.

// File: rtl/svl_pkg.sv
package svl_pkg;
  typedef enum logic {ST_IDLE, ST_BUSY} svl_state_e;
  localparam int unsigned MIN_STRIDE = 2;
endpackage

// File: rtl/svl_addr_gen.sv
module svl_addr_gen #(
  parameter int unsigned AW = 32,
  parameter int unsigned TW = 3
) (
  input  logic [AW-1:0] base_i,
  input  logic [2:0]    stride_i,
  input  logic          wide_i,
  input  logic [TW-1:0] idx_i,
  output logic [AW-1:0] addr_o
);
  localparam int unsigned PW = TW + 3;
  logic [PW-1:0] elem_off;
  logic [PW+2:0] byte_off;

  always_comb begin
    elem_off = PW'(idx_i) * PW'(stride_i);
    byte_off = wide_i ? {elem_off, 3'b000} : {1'b0, elem_off, 2'b00};
    addr_o   = base_i + AW'(byte_off);
  end
endmodule

// File: rtl/svl_lane_track.sv
module svl_lane_track #(
  parameter int unsigned LANES = 8,
  parameter int unsigned TW    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          wide_i,
  input  logic          issue_i,
  input  logic          ret_i,
  input  logic [TW-1:0] ret_tag_i,
  output logic [TW-1:0] issue_idx_o,
  output logic          all_issued_o,
  output logic          last_ret_o
);
  logic [TW:0]      cnt_q;
  logic [LANES-1:0] ret_q, ret_nxt, need;
  logic [TW:0]      n_lanes;

  always_comb begin
    n_lanes = wide_i ? (TW+1)'(LANES/2) : (TW+1)'(LANES);
    need    = wide_i ? {{(LANES/2){1'b0}}, {(LANES/2){1'b1}}} : {LANES{1'b1}};
    ret_nxt = ret_q;
    if (ret_i) ret_nxt[ret_tag_i] = 1'b1;
  end

  assign issue_idx_o  = cnt_q[TW-1:0];
  assign all_issued_o = (cnt_q == n_lanes);
  assign last_ret_o   = ret_i && ((ret_nxt & need) == need);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ret_q <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
      ret_q <= '0;
    end else begin
      if (issue_i) cnt_q <= cnt_q + 1'b1;
      ret_q <= ret_nxt;
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= n_lanes);
  p_issue_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> !all_issued_o);
endmodule

// File: rtl/svl_vreg_image.sv
module svl_vreg_image #(
  parameter int unsigned VLEN = 256,
  parameter int unsigned TW   = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic            wide_i,
  input  logic [TW-1:0]   tag_i,
  input  logic [63:0]     data_i,
  output logic [VLEN-1:0] img_o
);
  localparam int unsigned SLOTS = VLEN / 32;
  logic [VLEN-1:0] img_q;

  for (genvar j = 0; j < SLOTS; j++) begin : g_slot
    logic hit;
    logic [31:0] wval;
    always_comb begin
      hit  = wide_i ? (32'(tag_i) == j / 2) : (32'(tag_i) == j);
      wval = (wide_i && (j % 2 == 1)) ? data_i[63:32] : data_i[31:0];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          img_q[j*32 +: 32] <= '0;
      else if (wr_i && hit) img_q[j*32 +: 32] <= wval;
    end
  end

  assign img_o = img_q;

  p_vreg_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(img_q));
endmodule

// File: rtl/strided_vec_lsu.sv
module strided_vec_lsu
  import svl_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned VLEN = 256
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  output logic            cmd_ready_o,
  input  logic            cmd_store_i,
  input  logic            cmd_wide_i,
  input  logic [2:0]      cmd_stride_i,
  input  logic [AW-1:0]   cmd_base_i,
  input  logic [VLEN-1:0] cmd_wdata_i,
  output logic            req_valid_o,
  input  logic            req_ready_i,
  output logic [AW-1:0]   req_addr_o,
  output logic [2:0]      req_tag_o,
  output logic            req_we_o,
  output logic            req_wide_o,
  output logic [63:0]     req_wdata_o,
  input  logic            rsp_valid_i,
  input  logic [2:0]      rsp_tag_i,
  input  logic [63:0]     rsp_data_i,
  output logic [VLEN-1:0] vreg_o,
  output logic            done_o,
  output logic            err_o
);
  localparam int unsigned LANES = VLEN / 32;
  localparam int unsigned TW    = $clog2(LANES);

  svl_state_e      state_q;
  logic            store_q, wide_q;
  logic [2:0]      stride_q;
  logic [AW-1:0]   base_q;
  logic [VLEN-1:0] wdata_q;
  logic            done_q, err_q;

  logic cmd_fire, legal, start, req_fire, rsp_take, finish;
  logic [TW-1:0] issue_idx;
  logic all_issued, last_ret;

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign cmd_fire    = cmd_valid_i && cmd_ready_o;
  assign legal       = 32'(cmd_stride_i) >= MIN_STRIDE;
  assign start       = cmd_fire && legal;
  assign req_valid_o = (state_q == ST_BUSY) && !all_issued;
  assign req_fire    = req_valid_o && req_ready_i;
  assign rsp_take    = (state_q == ST_BUSY) && rsp_valid_i;
  assign finish      = rsp_take && last_ret;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      store_q  <= 1'b0;
      wide_q   <= 1'b0;
      stride_q <= '0;
      base_q   <= '0;
      wdata_q  <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= finish;
      err_q  <= cmd_fire && !legal;
      if (start) begin
        state_q  <= ST_BUSY;
        store_q  <= cmd_store_i;
        wide_q   <= cmd_wide_i;
        stride_q <= cmd_stride_i;
        base_q   <= cmd_base_i;
        wdata_q  <= cmd_wdata_i;
      end else if (finish) begin
        state_q <= ST_IDLE;
      end
    end
  end

  svl_lane_track #(.LANES(LANES), .TW(TW)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .wide_i      (wide_q),
    .issue_i     (req_fire),
    .ret_i       (rsp_take),
    .ret_tag_i   (rsp_tag_i[TW-1:0]),
    .issue_idx_o (issue_idx),
    .all_issued_o(all_issued),
    .last_ret_o  (last_ret)
  );

  svl_addr_gen #(.AW(AW), .TW(TW)) u_addr (
    .base_i  (base_q),
    .stride_i(stride_q),
    .wide_i  (wide_q),
    .idx_i   (issue_idx),
    .addr_o  (req_addr_o)
  );

  svl_vreg_image #(.VLEN(VLEN), .TW(TW)) u_img (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (rsp_take && !store_q),
    .wide_i(wide_q),
    .tag_i (rsp_tag_i[TW-1:0]),
    .data_i(rsp_data_i),
    .img_o (vreg_o)
  );

  always_comb begin
    req_tag_o  = 3'(issue_idx);
    req_we_o   = store_q;
    req_wide_o = wide_q;
    if (wide_q) req_wdata_o = wdata_q[{issue_idx[TW-2:0], 6'd0} +: 64];
    else        req_wdata_o = {32'd0, wdata_q[{issue_idx, 5'd0} +: 32]};
  end

  assign done_o = done_q;
  assign err_o  = err_q;

  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o)
      && $stable(req_tag_o) && $stable(req_wdata_o));
  p_err_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> cmd_ready_o && !req_valid_o);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_busy_block_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !cmd_ready_o);
endmodule

// File: tb/strided_vec_lsu_test.sv
module strided_vec_lsu_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_valid = 0, cmd_store = 0, cmd_wide = 0;
  logic [2:0] cmd_stride = 0;
  logic [31:0] cmd_base = 0;
  logic [255:0] cmd_wdata = 0;
  logic cmd_ready, req_valid, req_ready = 0, req_we, req_wide;
  logic [31:0] req_addr;
  logic [2:0] req_tag;
  logic [63:0] req_wdata;
  logic rsp_valid = 0;
  logic [2:0] rsp_tag = 0;
  logic [63:0] rsp_data = 0;
  logic [255:0] vreg;
  logic done, err;

  int checks = 0, errs = 0;
  logic [255:0] exp_vreg = '0;

  always #2 clk = ~clk;

  strided_vec_lsu uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_store_i(cmd_store),
    .cmd_wide_i(cmd_wide), .cmd_stride_i(cmd_stride), .cmd_base_i(cmd_base),
    .cmd_wdata_i(cmd_wdata),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_addr_o(req_addr),
    .req_tag_o(req_tag), .req_we_o(req_we), .req_wide_o(req_wide),
    .req_wdata_o(req_wdata),
    .rsp_valid_i(rsp_valid), .rsp_tag_i(rsp_tag), .rsp_data_i(rsp_data),
    .vreg_o(vreg), .done_o(done), .err_o(err)
  );

  function automatic logic [63:0] mem_word(logic [31:0] a);
    return {a ^ 32'h5a5a_0f0f, a * 32'd3 + 32'd17};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input bit st, input bit wide, input logic [2:0] stride,
                        input logic [31:0] base, input int mode, input bit poke);
    int n = wide ? 4 : 8;
    int eb = wide ? 8 : 4;
    int got = 0;
    int guard = 0;
    int ord[8];
    logic [255:0] wd = {8{$urandom()}} ^ {$urandom(), $urandom(), $urandom(),
                        $urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
    @(negedge clk);
    cmd_valid = 1; cmd_store = st; cmd_wide = wide; cmd_stride = stride;
    cmd_base = base; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 0;
    chk(cmd_ready == 1'b0, "R10 ready low while busy", 256'(cmd_ready), 0);
    while (got < n && guard < 200) begin
      bit rdy = (mode == 0) ? 1'b1 : 1'($urandom() % 2);
      req_ready = rdy;
      if (req_valid && rdy) begin
        logic [31:0] ea = base + 32'(got * int'(stride) * eb);
        logic [63:0] ew = wide ? wd[got*64 +: 64] : {32'd0, wd[got*32 +: 32]};
        chk(req_tag == 3'(got), "R2 tag order", 256'(req_tag), 256'(got));
        chk(req_addr == ea, "R2 lane address", 256'(req_addr), 256'(ea));
        chk(req_wide == wide, "R3 access size", 256'(req_wide), 256'(wide));
        chk(req_we == st, "R9 write flag", 256'(req_we), 256'(st));
        if (st) chk(req_wdata == ew, "R9 store lane data", 256'(req_wdata), 256'(ew));
        got++;
      end
      @(negedge clk);
      guard++;
    end
    req_ready = 0;
    chk(got == n, "R3 request count", 256'(got), 256'(n));
    chk(req_valid == 1'b0, "R3 no extra request", 256'(req_valid), 0);
    chk(done == 1'b0, "R8 no early done", 256'(done), 0);
    if (poke) begin
      cmd_valid = 1; cmd_store = 1; cmd_wide = 0; cmd_stride = 3;
      @(negedge clk);
      cmd_valid = 0;
      chk(cmd_ready == 1'b0, "R10 busy command refused", 256'(cmd_ready), 0);
      @(negedge clk);
      chk(req_valid == 1'b0, "R10 no request from busy command", 256'(req_valid), 0);
      chk(vreg == exp_vreg, "R10 image untouched", vreg, exp_vreg);
    end
    for (int k = 0; k < n; k++) ord[k] = (mode == 1) ? n - 1 - k : k;
    if (mode == 2)
      for (int k = n - 1; k > 0; k--) begin
        int j = int'($urandom() % (k + 1));
        int t = ord[k];
        ord[k] = ord[j]; ord[j] = t;
      end
    for (int k = 0; k < n; k++) begin
      logic [31:0] a = base + 32'(ord[k] * int'(stride) * eb);
      logic [63:0] m = mem_word(a);
      if (mode == 2) repeat ($urandom() % 3) @(negedge clk);
      rsp_valid = 1; rsp_tag = 3'(ord[k]); rsp_data = st ? 64'hdead_beef_0bad_f00d : m;
      @(negedge clk);
      rsp_valid = 0;
      if (!st) begin
        if (wide) exp_vreg[ord[k]*64 +: 64] = m;
        else      exp_vreg[ord[k]*32 +: 32] = m[31:0];
      end
      if (st) chk(vreg == exp_vreg, "R9 store keeps image", vreg, exp_vreg);
      else if (k < n - 1) chk(vreg == exp_vreg, "R7 pending lanes hold", vreg, exp_vreg);
      else chk(vreg == exp_vreg, "R6 final image", vreg, exp_vreg);
      if (k < n - 1) chk(done == 1'b0, "R8 done before last", 256'(done), 0);
      else           chk(done == 1'b1, "R8 done after last", 256'(done), 1);
    end
    @(negedge clk);
    chk(done == 1'b0, "R8 done single pulse", 256'(done), 0);
    chk(cmd_ready == 1'b1, "R10 idle after done", 256'(cmd_ready), 1);
  endtask

  task automatic test_illegal();
    for (int s = 0; s < 2; s++) begin
      @(negedge clk);
      cmd_valid = 1; cmd_store = 0; cmd_wide = 1; cmd_stride = 3'(s); cmd_base = 32'h40;
      @(negedge clk);
      cmd_valid = 0;
      chk(err == 1'b1, "R4 error flagged", 256'(err), 1);
      chk(req_valid == 1'b0, "R4 no request", 256'(req_valid), 0);
      chk(cmd_ready == 1'b1, "R4 stays idle", 256'(cmd_ready), 1);
      @(negedge clk);
      chk(err == 1'b0, "R4 error is a pulse", 256'(err), 0);
      chk(req_valid == 1'b0, "R4 still no request", 256'(req_valid), 0);
      chk(vreg == exp_vreg, "R4 image unchanged", vreg, exp_vreg);
    end
  endtask

  task automatic test_reset();
    chk(done == 0 && err == 0 && req_valid == 0, "R1 outputs in reset",
        256'({done, err, req_valid}), 0);
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 ready after reset", 256'(cmd_ready), 1);
    chk(vreg == '0, "R1 image cleared", vreg, 0);
    chk(done == 0 && err == 0 && req_valid == 0, "R1 outputs after reset",
        256'({done, err, req_valid}), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    for (int s = 2; s < 8; s++) run_op(0, 1, 3'(s), 32'h1000 + 32'(s * 8), 0, 0);
    for (int s = 2; s < 8; s++) run_op(0, 0, 3'(s), 32'h2004 + 32'(s * 4), 1, 0);
    for (int s = 2; s < 8; s++) run_op(0, 0, 3'(s), 32'h3000, 2, 0);
    for (int s = 2; s < 8; s++) run_op(0, 1, 3'(s), 32'h4008, 2, 0);
    test_illegal();
    run_op(0, 1, 3'd5, 32'h5000, 2, 1);
    run_op(1, 1, 3'd2, 32'h6000, 2, 0);
    run_op(1, 0, 3'd7, 32'h7010, 1, 1);
    run_op(1, 0, 3'd4, 32'h8000, 2, 0);
    test_illegal();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule